// File: doc/BRIEF.md
# PIO Sample Byte Sequencer

This block is the byte-wide programmed-I/O data port of an audio codec. One bus address serves two registers. A host write always fills the playback register and a host read always drains the capture register. A multi-byte audio sample moves through the 8-bit port one byte at a time. Two small trackers keep the position within the sample, one for playback and one for capture, so the host never gives a byte index. Both positions are shown on status outputs, so the host can see which byte comes next.

The capture tracker reloads whenever the ADC side presents a new sample. It then stops on the final byte and does not wrap. The playback tracker fills a word from most to least significant byte and drops any write beyond the sample length. It restarts when the DAC side takes the word. While the device is initialising, the port is held in a fixed state: writes do nothing, reads return 8'h80, and neither position moves. Two sticky error flags report a capture sample that was overwritten before it was read in full, and a playback sample that was taken before it was complete.

Top module: `pio_byte_port`

## Requirements
- R1: A strobe with `bus_we`=1 only writes the playback side. A strobe with `bus_we`=0 only reads the capture side. A write leaves `cap_pos` and the capture byte unchanged, and a read leaves `play_pos` and `play_word` unchanged.
- R2: While `init_busy`=1, `bus_rdata` is 8'h80. Reads do not advance `cap_pos`. Writes change neither `play_pos`, `play_word` nor `play_valid`.
- R3: With N bytes per sample, capture byte k (k = 0 first) is `adc_word[(N-1-k)*8 +: 8]`, so the most significant byte comes first. Each read advances `cap_pos` by one, and `cap_pos` equals the index of the byte that `bus_rdata` presents.
- R4: Once `cap_pos` reaches N-1, further reads keep it at N-1 and keep returning the last byte.
- R5: A cycle with `adc_ready`=1 latches `adc_word` and sets `cap_pos` to 0 at the next edge.
- R6: Playback byte k written goes to `play_word[(N-1-k)*8 +: 8]`. Bytes above the sample stay zero. `play_pos` counts the bytes written so far, from 0 to N.
- R7: When `play_pos`=N, further writes change neither `play_word` nor `play_pos`.
- R8: `play_valid` rises at the edge that stores byte N-1. `dac_take` clears `play_valid`, `play_pos` and `play_word` to zero at the next edge.
- R9: The format encoding is `fmt` 0 = 8-bit mono (N=1), 1 = 8-bit stereo (N=2), 2 = 16-bit mono (N=2) and 3 = 16-bit stereo (N=4).
- R10: `dac_take` while `play_valid`=0 sets the sticky `play_underrun`. A cycle with `stat_clr`=1 clears it.
- R11: `adc_ready` while bytes of the held sample are still unread sets the sticky `cap_overrun`. The first sample after reset, or one arriving after the last byte was read, does not set it. `stat_clr` clears it, and a new overrun takes priority over the clear.
- R12: If a write and `dac_take` fall in the same cycle, the take happens first and the written byte becomes byte 0 of the next sample. If a read and `adc_ready` fall in the same cycle, the read returns the old byte and `cap_pos` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Sample format select |
| init_busy | input | 1 | Device initialising; locks the port |
| bus_sel | input | 1 | Host access strobe, one cycle per byte |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 8 | Playback byte |
| bus_rdata | output | 8 | Capture byte presented during a read |
| stat_clr | input | 1 | Status write clearing both error flags |
| adc_ready | input | 1 | New ADC sample present |
| adc_word | input | 32 | ADC sample, right-aligned |
| dac_take | input | 1 | DAC takes the playback word |
| play_word | output | 32 | Assembled playback sample, right-aligned |
| play_valid | output | 1 | Playback sample complete |
| cap_pos | output | 2 | Next capture byte index |
| play_pos | output | 3 | Playback bytes written |
| cap_overrun | output | 1 | Sticky capture overrun |
| play_underrun | output | 1 | Sticky playback underrun |

## Verification
Capture is first read through a whole 4-byte sample and then read past its end. This separates correct byte ordering from pointer wrap or runaway. The same sequence is repeated with the 1- and 2-byte formats, which exposes a sample length taken from the wrong format code. Playback is filled, overfilled and taken, and the bench compares the assembled word after each step, which catches lane misplacement and surplus writes leaking in. Same-cycle collisions, a read and a write issued while initialising, and early ADC samples or DAC takes each show whether the priority between host and converter is right and whether the sticky flags are set and cleared at the right moment.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 4;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);

  typedef enum logic [1:0] {
    FMT_8_MONO    = 2'd0,
    FMT_8_STEREO  = 2'd1,
    FMT_16_MONO   = 2'd2,
    FMT_16_STEREO = 2'd3
  } fmt_e;

  // bytes per sample for a format code
  function automatic logic [CNT_W-1:0] bytes_per(input logic [1:0] code);
    logic [CNT_W-1:0] n;
    case (fmt_e'(code))
      FMT_8_MONO:    n = CNT_W'(1);
      FMT_8_STEREO:  n = CNT_W'(2);
      FMT_16_MONO:   n = CNT_W'(2);
      default:       n = CNT_W'(4);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/pio_rst_sync.sv
`timescale 1ns/1ps
module pio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb shift_d = {shift_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_n_sync = shift_q[STAGES-1];
endmodule

// File: rtl/pio_cap_track.sv
`timescale 1ns/1ps
module pio_cap_track #(
  parameter int BYTE_W    = pio_pkg::BYTE_W,
  parameter int MAX_BYTES = pio_pkg::MAX_BYTES
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [pio_pkg::CNT_W-1:0]     nbytes,
  input  logic                          rd_stb,
  input  logic                          smp_stb,
  input  logic [MAX_BYTES*BYTE_W-1:0]   smp_word,
  input  logic                          flag_clr,
  output logic [BYTE_W-1:0]             rd_byte,
  output logic [((MAX_BYTES>1)?$clog2(MAX_BYTES):1)-1:0] pos,
  output logic                          overrun
);
  localparam int CNT_W = pio_pkg::CNT_W;
  localparam int PTR_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  logic [MAX_BYTES-1:0][BYTE_W-1:0] hold_q;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             pend_q, pend_d;
  logic             ovr_q, ovr_d;
  logic [CNT_W-1:0] last_c;
  logic             at_last, rd_last;
  logic [PTR_W-1:0] lane_sel;

  always_comb begin
    last_c   = nbytes - CNT_W'(1);
    at_last  = CNT_W'(ptr_q) >= last_c;
    rd_last  = rd_stb && at_last;
    lane_sel = at_last ? '0 : PTR_W'(last_c - CNT_W'(ptr_q));
    ptr_d    = ptr_q;
    pend_d   = pend_q;
    ovr_d    = ovr_q && !flag_clr;
    if (smp_stb) begin
      ptr_d  = '0;
      pend_d = 1'b1;
      if (pend_q && !rd_last) ovr_d = 1'b1;
    end else if (rd_stb) begin
      if (!at_last) ptr_d = ptr_q + PTR_W'(1);
      if (rd_last)  pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
    end
  end

  // sample holding register, enabled by the converter strobe only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (smp_stb) hold_q <= smp_word;
  end

  assign rd_byte = hold_q[lane_sel];
  assign pos     = ptr_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/pio_play_lane.sv
`timescale 1ns/1ps
module pio_play_lane #(
  parameter int BYTE_W = pio_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] q
);
  logic [BYTE_W-1:0] q_d;
  logic              en;

  always_comb begin
    en  = load || clr;
    q_d = load ? din : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_d;
  end
endmodule

// File: rtl/pio_play_track.sv
`timescale 1ns/1ps
module pio_play_track #(
  parameter int BYTE_W    = pio_pkg::BYTE_W,
  parameter int MAX_BYTES = pio_pkg::MAX_BYTES
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [pio_pkg::CNT_W-1:0]   nbytes,
  input  logic                        wr_stb,
  input  logic [BYTE_W-1:0]           wr_byte,
  input  logic                        take,
  input  logic                        flag_clr,
  output logic [MAX_BYTES*BYTE_W-1:0] word,
  output logic                        valid,
  output logic [pio_pkg::CNT_W-1:0]   pos,
  output logic                        underrun
);
  localparam int CNT_W = pio_pkg::CNT_W;

  logic [CNT_W-1:0] ptr_q, ptr_d, ptr_eff, lane_idx;
  logic             val_q, val_d;
  logic             unr_q, unr_d;
  logic             wr_ok;

  always_comb begin
    ptr_eff  = take ? '0 : ptr_q;
    wr_ok    = wr_stb && (ptr_eff < nbytes);
    lane_idx = nbytes - CNT_W'(1) - ptr_eff;
    ptr_d    = ptr_eff + CNT_W'(wr_ok);
    val_d    = val_q && !take;
    if (wr_ok && ((ptr_eff + CNT_W'(1)) == nbytes)) val_d = 1'b1;
    unr_d    = (unr_q && !flag_clr) || (take && !val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      val_q <= 1'b0;
      unr_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      val_q <= val_d;
      unr_q <= unr_d;
    end
  end

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_lane
    pio_play_lane #(.BYTE_W(BYTE_W)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .load (wr_ok && (lane_idx == CNT_W'(i))),
      .clr  (take),
      .din  (wr_byte),
      .q    (word[i*BYTE_W +: BYTE_W])
    );
  end

  assign valid    = val_q;
  assign pos      = ptr_q;
  assign underrun = unr_q;
endmodule

// File: rtl/pio_byte_port.sv
`timescale 1ns/1ps
module pio_byte_port #(
  parameter int          BYTE_W    = pio_pkg::BYTE_W,
  parameter int          MAX_BYTES = pio_pkg::MAX_BYTES,
  parameter logic [7:0]  INIT_FILL = 8'h80
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  fmt,
  input  logic                        init_busy,
  input  logic                        bus_sel,
  input  logic                        bus_we,
  input  logic [BYTE_W-1:0]           bus_wdata,
  output logic [BYTE_W-1:0]           bus_rdata,
  input  logic                        stat_clr,
  input  logic                        adc_ready,
  input  logic [MAX_BYTES*BYTE_W-1:0] adc_word,
  input  logic                        dac_take,
  output logic [MAX_BYTES*BYTE_W-1:0] play_word,
  output logic                        play_valid,
  output logic [((MAX_BYTES>1)?$clog2(MAX_BYTES):1)-1:0] cap_pos,
  output logic [pio_pkg::CNT_W-1:0]   play_pos,
  output logic                        cap_overrun,
  output logic                        play_underrun
);
  logic                             rst_n_int;
  logic [pio_pkg::CNT_W-1:0]        nbytes;
  logic                             host_rd, host_wr;
  logic [BYTE_W-1:0]                cap_byte;

  pio_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  always_comb begin
    nbytes  = pio_pkg::bytes_per(fmt);
    host_rd = bus_sel && !bus_we && !init_busy;
    host_wr = bus_sel &&  bus_we && !init_busy;
  end

  pio_cap_track #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .nbytes  (nbytes),
    .rd_stb  (host_rd),
    .smp_stb (adc_ready),
    .smp_word(adc_word),
    .flag_clr(stat_clr),
    .rd_byte (cap_byte),
    .pos     (cap_pos),
    .overrun (cap_overrun)
  );

  pio_play_track #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) u_play (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .nbytes  (nbytes),
    .wr_stb  (host_wr),
    .wr_byte (bus_wdata),
    .take    (dac_take),
    .flag_clr(stat_clr),
    .word    (play_word),
    .valid   (play_valid),
    .pos     (play_pos),
    .underrun(play_underrun)
  );

  assign bus_rdata = init_busy ? INIT_FILL[BYTE_W-1:0] : cap_byte;
endmodule

// File: rtl/pio_byte_port_chk.sv
`timescale 1ns/1ps
module pio_byte_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  fmt,
  input logic        init_busy,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [7:0]  bus_rdata,
  input logic        stat_clr,
  input logic        adc_ready,
  input logic        dac_take,
  input logic [31:0] play_word,
  input logic        play_valid,
  input logic [1:0]  cap_pos,
  input logic [2:0]  play_pos,
  input logic        cap_overrun,
  input logic        play_underrun
);
  logic [2:0] n_chk;
  logic       cap_at_end;

  always_comb begin
    n_chk      = pio_pkg::bytes_per(fmt);
    cap_at_end = ({1'b0, cap_pos} == (n_chk - 3'd1));
  end

  AST_INIT_READ_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> bus_rdata == 8'h80); // R2

  AST_INIT_PLAY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (init_busy && !dac_take) |=> ($stable(play_pos) && $stable(play_word))); // R2

  AST_WRITE_KEEPS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && !adc_ready) |=> $stable(cap_pos)); // R1

  AST_CAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ready |=> cap_pos == 2'd0); // R5

  AST_CAP_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !adc_ready && cap_at_end) |=> $stable(cap_pos)); // R4

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_take && !(bus_sel && bus_we)) |=> (play_pos == 3'd0 && !play_valid)); // R8

  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_take && !play_valid) |=> play_underrun); // R10

  AST_OVERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !adc_ready) |=> !cap_overrun); // R11
endmodule

bind pio_byte_port pio_byte_port_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n_int),
  .fmt          (fmt),
  .init_busy    (init_busy),
  .bus_sel      (bus_sel),
  .bus_we       (bus_we),
  .bus_rdata    (bus_rdata),
  .stat_clr     (stat_clr),
  .adc_ready    (adc_ready),
  .dac_take     (dac_take),
  .play_word    (play_word),
  .play_valid   (play_valid),
  .cap_pos      (cap_pos),
  .play_pos     (play_pos),
  .cap_overrun  (cap_overrun),
  .play_underrun(play_underrun)
);

// File: tb/test_pio_byte_port.sv
`timescale 1ns/1ps
module test_pio_byte_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'd3;
  logic        init_busy = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        stat_clr = 1'b0;
  logic        adc_ready = 1'b0;
  logic [31:0] adc_word = '0;
  logic        dac_take = 1'b0;
  logic [31:0] play_word;
  logic        play_valid;
  logic [1:0]  cap_pos;
  logic [2:0]  play_pos;
  logic        cap_overrun;
  logic        play_underrun;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  pio_byte_port i_pio_byte_port (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .init_busy(init_busy),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .stat_clr(stat_clr), .adc_ready(adc_ready),
    .adc_word(adc_word), .dac_take(dac_take), .play_word(play_word),
    .play_valid(play_valid), .cap_pos(cap_pos), .play_pos(play_pos),
    .cap_overrun(cap_overrun), .play_underrun(play_underrun)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares read data mid-cycle against the scoreboard
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_we) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R1 unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({24'd0, bus_rdata}, {24'd0, e}, t);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_sel = 1'b1; bus_we = 1'b0;
    step();
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = d;
    step();
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic adc(input logic [31:0] w);
    adc_ready = 1'b1; adc_word = w;
    step();
    adc_ready = 1'b0;
  endtask

  task automatic take();
    dac_take = 1'b1;
    step();
    dac_take = 1'b0;
  endtask

  task automatic clr();
    stat_clr = 1'b1;
    step();
    stat_clr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    // reset state
    chk({30'd0, cap_pos}, 0, "reset cap_pos");
    chk({29'd0, play_pos}, 0, "reset play_pos");
    chk({29'd0, play_valid, cap_overrun, play_underrun}, 0, "reset flags");

    // R2: locked while initialising
    init_busy = 1'b1;
    rd(8'h80, "R2 init read");
    wr(8'hAA);
    chk({29'd0, play_pos}, 0, "R2 init write ignored");
    chk(play_word, 0, "R2 init write word");
    init_busy = 1'b0;

    // R3 / R4: 16-bit stereo capture
    fmt = 2'd3;
    adc(32'h11223344);
    chk({30'd0, cap_pos}, 0, "R5 restart pos");
    rd(8'h11, "R3 byte0");
    rd(8'h22, "R3 byte1");
    chk({30'd0, cap_pos}, 2, "R3 pos after two");
    rd(8'h33, "R3 byte2");
    rd(8'h44, "R3 byte3");
    rd(8'h44, "R4 saturate repeat");
    chk({30'd0, cap_pos}, 3, "R4 pos held");
    chk({31'd0, cap_overrun}, 0, "R11 no overrun first");

    // R6 / R7 / R8 playback fill
    wr(8'hA1);
    chk({30'd0, cap_pos}, 3, "R1 write keeps cap_pos");
    chk({29'd0, play_pos}, 1, "R6 pos one");
    wr(8'hA2); wr(8'hA3);
    chk({31'd0, play_valid}, 0, "R8 valid not early");
    wr(8'hA4);
    chk({31'd0, play_valid}, 1, "R8 valid on last");
    chk(play_word, 32'hA1A2A3A4, "R6 word assembled");
    wr(8'h55);
    chk(play_word, 32'hA1A2A3A4, "R7 surplus ignored");
    chk({29'd0, play_pos}, 4, "R7 pos saturated");
    rd(8'h44, "R1 read after writes");
    chk(play_word, 32'hA1A2A3A4, "R1 read keeps play_word");
    take();
    chk({29'd0, play_pos, play_valid}, 0, "R8 take clears");
    chk(play_word, 0, "R8 take zeroes word");
    chk({31'd0, play_underrun}, 0, "R10 no underrun on full");
    take();
    chk({31'd0, play_underrun}, 1, "R10 underrun set");
    clr();
    chk({31'd0, play_underrun}, 0, "R10 underrun cleared");

    // R11 overrun
    adc(32'h55667788);
    rd(8'h55, "R3 next sample");
    adc(32'h99AABBCC);
    chk({31'd0, cap_overrun}, 1, "R11 overrun set");
    chk({30'd0, cap_pos}, 0, "R5 pos reload");
    rd(8'h99, "R5 new sample msb");
    clr();
    chk({31'd0, cap_overrun}, 0, "R11 overrun cleared");

    // R9 8-bit mono
    fmt = 2'd0;
    adc(32'h000000F0);
    clr();
    rd(8'hF0, "R9 mono byte");
    rd(8'hF0, "R4 mono saturate");
    chk({30'd0, cap_pos}, 0, "R4 mono pos");
    wr(8'h5A);
    chk({31'd0, play_valid}, 1, "R9 mono valid");
    chk(play_word, 32'h0000005A, "R9 mono word");
    take();

    // R9 8-bit stereo
    fmt = 2'd1;
    wr(8'h12); wr(8'h34); wr(8'h56);
    chk(play_word, 32'h00001234, "R9 stereo word");
    chk({29'd0, play_pos}, 2, "R7 stereo pos");
    take();
    adc(32'hDEADBEEF);
    chk({31'd0, cap_overrun}, 0, "R11 no overrun after full read");
    rd(8'hBE, "R9 stereo byte0");
    rd(8'hEF, "R9 stereo byte1");
    rd(8'hEF, "R4 stereo saturate");

    // R9 16-bit mono
    fmt = 2'd2;
    adc(32'h0000CAFE);
    rd(8'hCA, "R9 16mono byte0");
    rd(8'hFE, "R9 16mono byte1");

    // R12 collisions
    fmt = 2'd3;
    wr(8'h01);
    bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = 8'h77; dac_take = 1'b1;
    step();
    bus_sel = 1'b0; bus_we = 1'b0; dac_take = 1'b0;
    chk({29'd0, play_pos}, 1, "R12 take+write pos");
    chk(play_word, 32'h77000000, "R12 take+write word");
    chk({31'd0, play_underrun}, 1, "R10 early take underrun");
    clr();
    take();
    adc(32'h01020304);
    rd(8'h01, "R3 collide prep0");
    rd(8'h02, "R3 collide prep1");
    exp_q.push_back(8'h03); tag_q.push_back("R12 read+adc old byte");
    bus_sel = 1'b1; bus_we = 1'b0; adc_ready = 1'b1; adc_word = 32'h0A0B0C0D;
    step();
    bus_sel = 1'b0; adc_ready = 1'b0;
    chk({30'd0, cap_pos}, 0, "R12 read+adc pos");
    chk({31'd0, cap_overrun}, 1, "R11 collide overrun");
    rd(8'h0A, "R12 new sample first");
    clr();

    // R2 again: no advance during init
    init_busy = 1'b1;
    rd(8'h80, "R2 init read fixed");
    chk({30'd0, cap_pos}, 1, "R2 init no advance");
    wr(8'h99);
    chk({29'd0, play_pos}, 0, "R2 init write pos");
    init_busy = 1'b0;
    rd(8'h0B, "R2 resumes byte1");

    step(); step();
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 pending reads actual=%0d expected=0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule